// File: doc/BRIEF.md
# Parallel Fitness Scoring Register Block

This block sits beside a bank of eight configurable cell arrays and scores all of them at once against a stored truth table. Software-style accesses arrive over a simple address/data register port. Through it the user picks an array and a cell and streams 20-bit configuration words toward the arrays. The user also loads a 256-entry table of expected output bytes and chooses a test vector. That vector goes to every array input at the same time and also addresses the expected-output table.

Each array returns an 8-bit result. For every bit position the block forms an agreement bit: 1 when the array bit equals the expected bit, 0 when they differ. A mask then zeroes the positions that the evaluated circuit does not use. The raw array results and the masked agreement bytes can be read back four arrays per 32-bit word. The number of ones in an agreement byte is the score that array earns for the current vector.

The configuration pointer and the table pointer both advance on their own after each write. A whole cell array, or a whole truth table, can therefore be loaded by writing the same offset again and again.

Top module: `fiteval_ctrl`

## Requirements
- R1: After reset these read as zero: the array index, cell index, vector and mask registers, `bus_rvalid`, `bus_rdata`, `cfg_stb`, `vec_out` and every expected-table entry.
- R2: Writes store and read back, zero-extended, as follows: offset 0x00 holds the array index (3 bits), 0x04 the cell index (6 bits), 0x0C the vector (8 bits) and 0x10 the mask (8 bits).
- R3: A write to offset 0x08 raises `cfg_stb` for exactly one cycle, on the cycle after the write. With it, `cfg_arr` carries the array index, `cfg_cell` carries the cell index and `cfg_data` carries write data bits 19:0.
- R4: After each config write the cell index advances by one. An index of 39 advances to 0.
- R5: A write to offset 0x14 stores data bits 7:0 in the expected table at the current vector. The vector then advances by one, and 255 advances to 0.
- R6: A read of offset 0x14 returns the expected-table entry at the current vector and does not move the vector.
- R7: `vec_out` always equals the vector register. It changes only on a vector write or a table write.
- R8: A read of offset 0x18 returns the results of arrays 3..0 and a read of 0x1C returns arrays 7..4. Within each word the lowest-numbered array sits in bits 7:0 and each following array sits one byte higher.
- R9: Offsets 0x20 and 0x24 return the agreement bytes in the same packing as R8. Each bit is `mask & ~(expected ^ array)`, where the expected byte is the table entry at the current vector.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high one cycle after `bus_rd_en`. When `bus_rvalid` is low, `bus_rdata` is zero. Reads of offset 0x08 or of unmapped offsets return zero.
- R11: Writes to offsets 0x18 through 0x24, or to unmapped offsets, change no register and raise no `cfg_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write enable |
| bus_rd_en | input | 1 | Register read enable |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| cfg_stb | output | 1 | One-cycle configuration write strobe toward the arrays |
| cfg_arr | output | 3 | Target array of the configuration write |
| cfg_cell | output | 6 | Target cell of the configuration write |
| cfg_data | output | 20 | Configuration word |
| vec_out | output | 8 | Test vector driven to all arrays |
| arr_in | input | 64 | Array results, array k in bits 8k+7:8k |

## Verification
If a pointer advances wrongly, the fault shows on the very next strobe or read. The cell index appears on `cfg_cell` one cycle after a config write, and the vector appears on `vec_out` one cycle after a table write. A fault in the expected table or in the mask stays invisible until an agreement word is read. The bench therefore reads both agreement words under full and partial masks, and against results that match the table and results that do not. A wrong byte lane in the packing shows on the first output-word read, because every array is driven with a distinct byte.

// File: rtl/fe_pkg.sv
package fe_pkg;
   // Register word indices (byte offset / 4); the word order is decoded by software.
   localparam int unsigned IDX_ARR   = 0;
   localparam int unsigned IDX_CELL  = 1;
   localparam int unsigned IDX_CFG   = 2;
   localparam int unsigned IDX_VEC   = 3;
   localparam int unsigned IDX_MASK  = 4;
   localparam int unsigned IDX_TRAM  = 5;
   localparam int unsigned IDX_WORDS = 6;   // first packed result word
endpackage

// File: rtl/fe_ptrs.sv
module fe_ptrs
   import fe_pkg::*;
#(
   parameter int ARR_W   = 3,
   parameter int CELL_W  = 6,
   parameter int N_CELLS = 40,
   parameter int VEC_W   = 8,
   parameter int OUT_W   = 8,
   parameter int CFG_W   = 20,
   parameter int IDX_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  widx,
   input  logic [CFG_W-1:0]  wdata,
   output logic [ARR_W-1:0]  arr_num,
   output logic [CELL_W-1:0] cell_num,
   output logic [VEC_W-1:0]  vec,
   output logic [OUT_W-1:0]  mask,
   output logic              tram_we,
   output logic              cfg_stb,
   output logic [ARR_W-1:0]  cfg_arr,
   output logic [CELL_W-1:0] cfg_cell,
   output logic [CFG_W-1:0]  cfg_data
);
   localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(N_CELLS - 1);

   logic hit_arr, hit_cell, hit_cfg, hit_vec, hit_mask, hit_tram;
   logic [CELL_W-1:0] cell_next;

   assign hit_arr  = wr_en && (widx == IDX_W'(IDX_ARR));
   assign hit_cell = wr_en && (widx == IDX_W'(IDX_CELL));
   assign hit_cfg  = wr_en && (widx == IDX_W'(IDX_CFG));
   assign hit_vec  = wr_en && (widx == IDX_W'(IDX_VEC));
   assign hit_mask = wr_en && (widx == IDX_W'(IDX_MASK));
   assign hit_tram = wr_en && (widx == IDX_W'(IDX_TRAM));
   assign tram_we  = hit_tram;

   assign cell_next = (cell_num >= LAST_CELL) ? '0 : cell_num + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr_num  <= '0;
         cell_num <= '0;
         vec      <= '0;
         mask     <= '0;
         cfg_stb  <= 1'b0;
         cfg_arr  <= '0;
         cfg_cell <= '0;
         cfg_data <= '0;
      end else begin
         if (hit_arr)  arr_num <= wdata[ARR_W-1:0];
         if (hit_cell)     cell_num <= wdata[CELL_W-1:0];
         else if (hit_cfg) cell_num <= cell_next;
         if (hit_vec)       vec <= wdata[VEC_W-1:0];
         else if (hit_tram) vec <= vec + 1'b1;
         if (hit_mask) mask <= wdata[OUT_W-1:0];
         cfg_stb <= hit_cfg;
         if (hit_cfg) begin
            cfg_arr  <= arr_num;
            cfg_cell <= cell_num;
            cfg_data <= wdata;
         end
      end
   end
endmodule

// File: rtl/fe_tram.sv
module fe_tram #(
   parameter int VEC_W          = 8,
   parameter int OUT_W          = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [VEC_W-1:0] addr,
   input  logic [OUT_W-1:0] wdata,
   output logic [OUT_W-1:0] q
);
   localparam int DEPTH = 1 << VEC_W;

   logic [OUT_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign q = mem[addr];
endmodule

// File: rtl/fe_match.sv
module fe_match #(
   parameter int N_ARR = 8,
   parameter int OUT_W = 8
) (
   input  logic [N_ARR*OUT_W-1:0] arr_in,
   input  logic [OUT_W-1:0]       target,
   input  logic [OUT_W-1:0]       mask,
   output logic [N_ARR*OUT_W-1:0] match
);
   for (genvar g = 0; g < N_ARR; g++) begin : g_arr
      assign match[g*OUT_W +: OUT_W] = mask & ~(target ^ arr_in[g*OUT_W +: OUT_W]);
   end
endmodule

// File: rtl/fe_rdmux.sv
module fe_rdmux
   import fe_pkg::*;
#(
   parameter int N_ARR  = 8,
   parameter int OUT_W  = 8,
   parameter int DATA_W = 32,
   parameter int ARR_W  = 3,
   parameter int CELL_W = 6,
   parameter int VEC_W  = 8,
   parameter int IDX_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic [IDX_W-1:0]       ridx,
   input  logic [ARR_W-1:0]       arr_num,
   input  logic [CELL_W-1:0]      cell_num,
   input  logic [VEC_W-1:0]       vec,
   input  logic [OUT_W-1:0]       mask,
   input  logic [OUT_W-1:0]       tram_q,
   input  logic [N_ARR*OUT_W-1:0] arr_in,
   input  logic [N_ARR*OUT_W-1:0] match,
   output logic [DATA_W-1:0]      rdata,
   output logic                   rvalid
);
   localparam int PER_WORD = DATA_W / OUT_W;
   localparam int N_WORDS  = N_ARR / PER_WORD;

   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      case (ridx)
         IDX_W'(IDX_ARR):  sel = DATA_W'(arr_num);
         IDX_W'(IDX_CELL): sel = DATA_W'(cell_num);
         IDX_W'(IDX_VEC):  sel = DATA_W'(vec);
         IDX_W'(IDX_MASK): sel = DATA_W'(mask);
         IDX_W'(IDX_TRAM): sel = DATA_W'(tram_q);
         default:          sel = '0;
      endcase
      for (int k = 0; k < N_WORDS; k++) begin
         if (ridx == IDX_W'(IDX_WORDS + k))
            sel = arr_in[k*DATA_W +: DATA_W];
         if (ridx == IDX_W'(IDX_WORDS + N_WORDS + k))
            sel = match[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_en;
         rdata  <= rd_en ? sel : '0;
      end
   end
endmodule

// File: rtl/fiteval_ctrl.sv
module fiteval_ctrl
   import fe_pkg::*;
#(
   parameter int N_ARR      = 8,
   parameter int OUT_W      = 8,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 6,
   parameter int N_CELLS    = 40,
   parameter int CELL_W     = 6,
   parameter int CFG_W      = 20,
   parameter int VEC_W      = 8,
   parameter bit TRAM_CLEAR = 1'b1,
   localparam int ARR_W     = $clog2(N_ARR)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr_en,
   input  logic                   bus_rd_en,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic                   bus_rvalid,
   output logic                   cfg_stb,
   output logic [ARR_W-1:0]       cfg_arr,
   output logic [CELL_W-1:0]      cfg_cell,
   output logic [CFG_W-1:0]       cfg_data,
   output logic [VEC_W-1:0]       vec_out,
   input  logic [N_ARR*OUT_W-1:0] arr_in
);
   localparam int IDX_W    = ADDR_W - 2;
   localparam int PER_WORD = DATA_W / OUT_W;
   localparam int N_WORDS  = N_ARR / PER_WORD;

   // elaboration-time parameter checks
   if (DATA_W % OUT_W != 0) begin : g_chk_lane
      $error("DATA_W must hold a whole number of array bytes");
   end
   if (N_ARR % PER_WORD != 0) begin : g_chk_pack
      $error("N_ARR must fill whole read words");
   end
   if ((1 << CELL_W) < N_CELLS) begin : g_chk_cell
      $error("CELL_W too narrow for N_CELLS");
   end
   if (CFG_W < VEC_W || CFG_W < OUT_W || CFG_W < CELL_W || CFG_W < ARR_W || CFG_W >= DATA_W) begin : g_chk_cfg
      $error("CFG_W must cover every register field and stay below DATA_W");
   end
   if ((1 << IDX_W) < IDX_WORDS + 2 * N_WORDS) begin : g_chk_map
      $error("ADDR_W too narrow for the register map");
   end

   logic [IDX_W-1:0]       widx;
   logic [ARR_W-1:0]       arr_num;
   logic [CELL_W-1:0]      cell_num;
   logic [OUT_W-1:0]       mask;
   logic                   tram_we;
   logic [OUT_W-1:0]       tram_q;
   logic [N_ARR*OUT_W-1:0] match;
   logic                   unused_bits;

   assign widx        = bus_addr[ADDR_W-1:2];
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CFG_W]};

   fe_ptrs #(
      .ARR_W(ARR_W), .CELL_W(CELL_W), .N_CELLS(N_CELLS), .VEC_W(VEC_W),
      .OUT_W(OUT_W), .CFG_W(CFG_W), .IDX_W(IDX_W)
   ) u_ptrs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .widx(widx),
      .wdata(bus_wdata[CFG_W-1:0]),
      .arr_num(arr_num), .cell_num(cell_num), .vec(vec_out), .mask(mask),
      .tram_we(tram_we), .cfg_stb(cfg_stb), .cfg_arr(cfg_arr),
      .cfg_cell(cfg_cell), .cfg_data(cfg_data)
   );

   fe_tram #(.VEC_W(VEC_W), .OUT_W(OUT_W), .CLEAR_ON_RESET(TRAM_CLEAR)) u_tram (
      .clk(clk), .rst_n(rst_n), .we(tram_we), .addr(vec_out),
      .wdata(bus_wdata[OUT_W-1:0]), .q(tram_q)
   );

   fe_match #(.N_ARR(N_ARR), .OUT_W(OUT_W)) u_match (
      .arr_in(arr_in), .target(tram_q), .mask(mask), .match(match)
   );

   fe_rdmux #(
      .N_ARR(N_ARR), .OUT_W(OUT_W), .DATA_W(DATA_W), .ARR_W(ARR_W),
      .CELL_W(CELL_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
   ) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .ridx(widx),
      .arr_num(arr_num), .cell_num(cell_num), .vec(vec_out), .mask(mask),
      .tram_q(tram_q), .arr_in(arr_in), .match(match),
      .rdata(bus_rdata), .rvalid(bus_rvalid)
   );
endmodule

// File: rtl/fe_checks.sv
module fe_checks #(
   parameter int N_ARR   = 8,
   parameter int OUT_W   = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 6,
   parameter int N_CELLS = 40,
   parameter int CELL_W  = 6,
   parameter int CFG_W   = 20,
   parameter int VEC_W   = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr_en,
   input logic                   bus_rd_en,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_wdata,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic                   bus_rvalid,
   input logic                   cfg_stb,
   input logic [CELL_W-1:0]      cfg_cell,
   input logic [CFG_W-1:0]       cfg_data,
   input logic [VEC_W-1:0]       vec_out,
   input logic [N_ARR*OUT_W-1:0] arr_in
);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [CELL_W-1:0] LAST_CELL = CELL_W'(N_CELLS - 1);

   logic [IDX_W-1:0] widx;
   logic w_cfg, w_vec, w_tram, r_out0;
   logic unused_chk;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign w_cfg  = bus_wr_en && (widx == IDX_W'(2));
   assign w_vec  = bus_wr_en && (widx == IDX_W'(3));
   assign w_tram = bus_wr_en && (widx == IDX_W'(5));
   assign r_out0 = bus_rd_en && (widx == IDX_W'(6));
   assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CFG_W], arr_in[N_ARR*OUT_W-1:DATA_W]};

   assert_cfg_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_cfg |=> cfg_stb);
   assert_cfg_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !w_cfg |=> !cfg_stb);
   assert_cfg_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      w_cfg |=> (cfg_data == $past(bus_wdata[CFG_W-1:0])));
   assert_cell_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stb && $past(cfg_stb)) |->
         (cfg_cell == (($past(cfg_cell) >= LAST_CELL) ? CELL_W'(0) : CELL_W'($past(cfg_cell) + 1'b1))));
   assert_vec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      w_tram |=> (vec_out == VEC_W'($past(vec_out) + 1'b1)));
   assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_vec || w_tram) |=> $stable(vec_out));
   assert_out_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
      r_out0 |=> (bus_rdata == $past(arr_in[DATA_W-1:0])));
   assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);
   assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> (!bus_rvalid && bus_rdata == '0));
endmodule

bind fiteval_ctrl fe_checks #(
   .N_ARR(N_ARR), .OUT_W(OUT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .N_CELLS(N_CELLS), .CELL_W(CELL_W), .CFG_W(CFG_W), .VEC_W(VEC_W)
) u_fe_checks (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_rvalid(bus_rvalid), .cfg_stb(cfg_stb), .cfg_cell(cfg_cell),
   .cfg_data(cfg_data), .vec_out(vec_out), .arr_in(arr_in)
);

// File: tb/tb_fiteval_ctrl.sv
`timescale 1ns/1ps
module tb_fiteval_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr_en, bus_rd_en;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        cfg_stb;
   logic [2:0]  cfg_arr;
   logic [5:0]  cfg_cell;
   logic [19:0] cfg_data;
   logic [7:0]  vec_out;
   logic [63:0] arr_in;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   fiteval_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .cfg_stb(cfg_stb), .cfg_arr(cfg_arr),
      .cfg_cell(cfg_cell), .cfg_data(cfg_data), .vec_out(vec_out), .arr_in(arr_in)
   );

   typedef struct packed {
      logic        wr;
      logic [5:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } step_t;

   localparam int N_STEPS = 19;
   localparam step_t STEPS [N_STEPS] = '{
      '{1'b1, 6'h00, 32'hFFFF_FFFD, 32'h0,         4'd2},   // R2 array index
      '{1'b0, 6'h00, 32'h0,         32'h5,         4'd2},
      '{1'b1, 6'h04, 32'h0000_001B, 32'h0,         4'd2},   // R2 cell index
      '{1'b0, 6'h04, 32'h0,         32'h1B,        4'd2},
      '{1'b1, 6'h0C, 32'h1234_56A5, 32'h0,         4'd2},   // R2 vector
      '{1'b0, 6'h0C, 32'h0,         32'hA5,        4'd2},
      '{1'b1, 6'h10, 32'h0000_01C3, 32'h0,         4'd2},   // R2 mask
      '{1'b0, 6'h10, 32'h0,         32'hC3,        4'd2},
      '{1'b0, 6'h18, 32'h0,         32'hB4A5_9687, 4'd8},   // R8 arrays 3..0
      '{1'b0, 6'h1C, 32'h0,         32'hF0E1_D2C3, 4'd8},   // R8 arrays 7..4
      '{1'b1, 6'h18, 32'hDEAD_BEEF, 32'h0,         4'd11},  // R11 read-only
      '{1'b1, 6'h24, 32'hFFFF_FFFF, 32'h0,         4'd11},
      '{1'b1, 6'h28, 32'h0000_0077, 32'h0,         4'd11},  // R11 unmapped
      '{1'b0, 6'h00, 32'h0,         32'h5,         4'd11},
      '{1'b0, 6'h10, 32'h0,         32'hC3,        4'd11},
      '{1'b0, 6'h0C, 32'h0,         32'hA5,        4'd11},
      '{1'b0, 6'h04, 32'h0,         32'h1B,        4'd11},
      '{1'b0, 6'h28, 32'h0,         32'h0,         4'd10},  // R10 unmapped read
      '{1'b0, 6'h08, 32'h0,         32'h0,         4'd10}   // R10 config read
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd_en = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
      chk("R10 rvalid", {63'b0, bus_rvalid}, 64'd1);
   endtask

   function automatic logic [31:0] exp_match(input logic [31:0] w, input logic [7:0] tgt,
                                             input logic [7:0] msk);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[i*8 +: 8] = msk & ~(tgt ^ w[i*8 +: 8]);
      return r;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
      bus_addr = '0; bus_wdata = '0; arr_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 vec_out", vec_out, 0);
      chk("R1 cfg_stb", cfg_stb, 0);
      chk("R1 rvalid", bus_rvalid, 0);
      chk("R1 rdata", bus_rdata, 0);
      rd(6'h00, got); chk("R1 arr idx", got, 0);
      rd(6'h04, got); chk("R1 cell idx", got, 0);
      rd(6'h0C, got); chk("R1 vector", got, 0);
      rd(6'h10, got); chk("R1 mask", got, 0);
      rd(6'h14, got); chk("R1 table entry", got, 0);

      // table-driven register walk
      arr_in = 64'hF0E1_D2C3_B4A5_9687;
      for (int i = 0; i < N_STEPS; i++) begin
         if (STEPS[i].wr) begin
            wr(STEPS[i].addr, STEPS[i].data);
            chk($sformatf("R11 no strobe step %0d", i), cfg_stb, 0);
         end else begin
            rd(STEPS[i].addr, got);
            chk($sformatf("R%0d step %0d", STEPS[i].req, i), got, STEPS[i].exp);
         end
      end

      // R10 idle read port
      @(negedge clk);
      chk("R10 rvalid idle", bus_rvalid, 0);
      chk("R10 rdata idle", bus_rdata, 0);

      // R3 config strobe, R4 cell wrap
      wr(6'h00, 32'h6);
      wr(6'h04, 32'd38);
      wr(6'h08, 32'hABCD_E123);
      chk("R3 strobe", cfg_stb, 1);
      chk("R3 array", cfg_arr, 6);
      chk("R3 cell", cfg_cell, 38);
      chk("R3 data", cfg_data, 20'hDE123);
      @(negedge clk);
      chk("R3 strobe one cycle", cfg_stb, 0);
      wr(6'h08, 32'h1);
      chk("R4 cell step", cfg_cell, 39);
      wr(6'h08, 32'h2);
      chk("R4 cell wrap", cfg_cell, 0);
      chk("R3 data 2", cfg_data, 20'h2);
      rd(6'h04, got); chk("R4 cell after wrap", got, 1);

      // R5 table fill, R6 table read, R7 vector output
      wr(6'h0C, 32'h10);
      wr(6'h14, 32'h3C);
      wr(6'h14, 32'h5A);
      wr(6'h14, 32'h99);
      rd(6'h0C, got); chk("R5 vector advance", got, 8'h13);
      chk("R7 vec_out", vec_out, 8'h13);
      wr(6'h0C, 32'h11);
      rd(6'h14, got); chk("R6 table read", got, 8'h5A);
      rd(6'h0C, got); chk("R6 no advance", got, 8'h11);
      chk("R7 vec_out hold", vec_out, 8'h11);
      wr(6'h0C, 32'hFF);
      wr(6'h14, 32'h81);
      rd(6'h0C, got); chk("R5 vector wrap", got, 0);
      chk("R7 vec_out wrap", vec_out, 0);
      wr(6'h0C, 32'hFF);
      rd(6'h14, got); chk("R6 top entry", got, 8'h81);

      // R9 agreement words, target 0x5A at vector 0x11
      wr(6'h0C, 32'h11);
      arr_in = 64'h5A00_FFA5_5A5B_0F7A;
      wr(6'h10, 32'hFF);
      rd(6'h20, got); chk("R9 full mask lo", got, exp_match(arr_in[31:0], 8'h5A, 8'hFF));
      rd(6'h24, got); chk("R9 full mask hi", got, exp_match(arr_in[63:32], 8'h5A, 8'hFF));
      rd(6'h18, got); chk("R8 new results", got, arr_in[31:0]);
      wr(6'h10, 32'h07);
      rd(6'h20, got); chk("R9 part mask lo", got, exp_match(arr_in[31:0], 8'h5A, 8'h07));
      rd(6'h24, got); chk("R9 part mask hi", got, exp_match(arr_in[63:32], 8'h5A, 8'h07));
      arr_in = {8{8'h5A}};
      wr(6'h10, 32'hFF);
      rd(6'h20, got); chk("R9 all agree lo", got, 32'hFFFF_FFFF);
      rd(6'h24, got); chk("R9 all agree hi", got, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule